// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts rising edges of that signal for a fixed time window and reports the total. The window is timed by a slow tick input, nominally 1 kHz, so one tick equals one millisecond. The IF input is asynchronous to the system clock and passes through a synchroniser first.

A controller selects one of four window lengths and raises a start bit. The 0-to-1 change of that bit starts a settling wait whose length depends on the window chosen. The window then opens and edges are counted. When the window closes, the count freezes and a completion flag rises. The flag can drive a shared open-drain line low to signal the end of the count. The controller reads the result while the start bit is still high. Lowering the bit at any time clears the result and the flag.

Dividing the count by the window length gives the frequency. For example, 342400 edges in a 32 ms window is 10.7 MHz.

Top module: `ifc_gated_counter`

## Requirements
- R1: `count_o` (CNT_W bits, default 20) holds the number of rising edges of `if_in` that reach the core during the open window. `if_in` passes through a two-stage synchroniser before edge detection.
- R2: `gate_sel_i` selects the window length in ticks: 0 gives 4, 1 gives 8, 2 gives 32 and 3 gives 64.
- R3: The window opens exactly 3 ticks after the start edge for selections 0 and 1, and exactly 7 ticks after it for selections 2 and 3. The selection is captured at the start edge, and later changes to `gate_sel_i` have no effect on that run.
- R4: Whenever `start_i` is sampled low, `count_o` and `done_o` are both 0 after the next clock edge. This holds even in the middle of a window.
- R5: Only a 0-to-1 change of `start_i` starts a run. If `start_i` is already high when reset is released, no run starts. Keeping `start_i` high after a run does not start another run.
- R6: Edges of `if_in` during the wait, and edges after the window closes, leave `count_o` unchanged.
- R7: The count saturates at 2^CNT_W-1 and does not wrap.
- R8: `done_o` is 0 during the wait and the window. It becomes 1 on the clock edge that samples the last window tick. It stays 1 while `start_i` remains high.
- R9: While `done_o` is 1, `count_o` is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start on rising edge; a low level clears the result |
| gate_sel_i | input | 2 | Window-length selection |
| if_in | input | 1 | Asynchronous IF signal whose edges are counted |
| tick_i | input | 1 | One-cycle timebase tick (1 ms nominal) |
| count_o | output | CNT_W | Edge count of the last or current window |
| done_o | output | 1 | Measurement complete |

## Verification
The following are checked by assertions on every cycle:
- a low start bit forces the sequencer idle;
- the captured selection stays fixed during a run;
- the completion flag is held while start stays high;
- the flag rises only after a tick;
- the count saturates and stays frozen when not enabled.

Only the bench scenarios can show the rest:
- the exact wait and window lengths, shown by edges toggled across the wait/window boundary being excluded;
- the absence of a run when start is already high at reset;
- the clearing of the result in the middle of a window.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_GATE = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ifc_seq.sv
module ifc_seq
  import ifc_pkg::*;
#(
  parameter int GATE_T0    = 4,
  parameter int GATE_T1    = 8,
  parameter int GATE_T2    = 32,
  parameter int GATE_T3    = 64,
  parameter int WAIT_SHORT = 3,
  parameter int WAIT_LONG  = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] gate_sel_i,
  input  logic       tick_i,
  output logic       gate_o,
  output logic       clear_o,
  output logic       done_o
);

  localparam int MAX_T  = max4(max4(GATE_T0, GATE_T1, GATE_T2, GATE_T3), WAIT_SHORT, WAIT_LONG, 1);
  localparam int TCNT_W = $clog2(MAX_T + 1);

  phase_t            phase_q;
  logic [1:0]        sel_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic              start_q;
  logic              arm;
  logic [TCNT_W-1:0] wait_len;
  logic [TCNT_W-1:0] gate_len;
  logic [TCNT_W-1:0] cur_len;
  logic              last_tick;

  assign arm = start_i & ~start_q;

  always_comb begin
    wait_len = sel_q[1] ? TCNT_W'(WAIT_LONG) : TCNT_W'(WAIT_SHORT);
    case (sel_q)
      2'd0:    gate_len = TCNT_W'(GATE_T0);
      2'd1:    gate_len = TCNT_W'(GATE_T1);
      2'd2:    gate_len = TCNT_W'(GATE_T2);
      default: gate_len = TCNT_W'(GATE_T3);
    endcase
    cur_len   = (phase_q == PH_WAIT) ? wait_len : gate_len;
    last_tick = tick_i && (tcnt_q == cur_len - TCNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b1;
    else     start_q <= start_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      sel_q   <= 2'd0;
      tcnt_q  <= '0;
    end else if (!start_i) begin
      phase_q <= PH_IDLE;
      tcnt_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (arm) begin
          phase_q <= PH_WAIT;
          sel_q   <= gate_sel_i;
          tcnt_q  <= '0;
        end
        PH_WAIT, PH_GATE: if (tick_i) begin
          if (last_tick) begin
            phase_q <= (phase_q == PH_WAIT) ? PH_GATE : PH_DONE;
            tcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + TCNT_W'(1);
          end
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  assign gate_o  = (phase_q == PH_GATE);
  assign done_o  = (phase_q == PH_DONE);
  assign clear_o = ~start_i | arm;

  // R4: a low start level returns the sequencer to idle
  a_r4_low_start_idles: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (phase_q == PH_IDLE));

  // R3: captured selection does not move during a run
  a_r3_sel_held: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && start_i) |=> $stable(sel_q));

  // R8: completion holds while start stays high
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> done_o);

  // R8: completion only follows a timebase tick
  a_r8_done_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(tick_i));

endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)             cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R7: a full counter stays full until cleared
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));

  // R6: no increment request leaves the value untouched
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter #(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2,
  parameter int GATE_T0     = 4,
  parameter int GATE_T1     = 8,
  parameter int GATE_T2     = 32,
  parameter int GATE_T3     = 64,
  parameter int WAIT_SHORT  = 3,
  parameter int WAIT_LONG   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             if_in,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);

  logic if_rise;
  logic gate_open;
  logic clear;
  logic done;

  ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (if_in),
    .rise_o  (if_rise)
  );

  ifc_seq #(
    .GATE_T0    (GATE_T0),
    .GATE_T1    (GATE_T1),
    .GATE_T2    (GATE_T2),
    .GATE_T3    (GATE_T3),
    .WAIT_SHORT (WAIT_SHORT),
    .WAIT_LONG  (WAIT_LONG)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .gate_sel_i (gate_sel_i),
    .tick_i     (tick_i),
    .gate_o     (gate_open),
    .clear_o    (clear),
    .done_o     (done)
  );

  ifc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clear),
    .inc_i (if_rise & gate_open),
    .cnt_o (count_o)
  );

  assign done_o = done;

  // R9: the result is frozen while completion is shown
  a_r9_result_stable: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> $stable(count_o));

endmodule

// File: tb/ifc_gated_counter_tb_top.sv
`timescale 1ns/1ps
module ifc_gated_counter_tb_top;

  localparam int CNT_W = 8;
  localparam int TOP   = (1 << CNT_W) - 1;
  localparam int TP    = 40;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [1:0]       gate_sel_i = 2'd0;
  logic             if_in = 1'b0;
  logic             tick_i = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ifc_gated_counter #(.CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .gate_sel_i (gate_sel_i),
    .if_in      (if_in),
    .tick_i     (tick_i),
    .count_o    (count_o),
    .done_o     (done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wait_of(input int s);
    return (s >= 2) ? 7 : 3;
  endfunction

  function automatic int gate_of(input int s);
    case (s)
      0: return 4;
      1: return 8;
      2: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic measure(input int sel, input int per, input bit swap_sel);
    int w, g, emitted;
    bit prev, nxt, in_gate, safe;
    w = wait_of(sel);
    g = gate_of(sel);
    @(negedge clk);
    start_i = 1'b0; tick_i = 1'b0; if_in = 1'b0;
    gate_sel_i = 2'(sel);
    repeat (3) @(negedge clk);
    chk("R4 clear count", int'(count_o), 0);
    chk("R4 clear done", int'(done_o), 0);
    start_i = 1'b1;
    emitted = 0;
    prev = 1'b0;
    for (int t = 0; t < w + g; t++) begin
      for (int c = 0; c < TP; c++) begin
        @(negedge clk);
        if (t == w + g - 1 && c == TP - 1)
          chk("R8 done low before last tick", int'(done_o), 0);
        in_gate = (t >= w);
        if (in_gate)
          safe = !(t == w && c < 8) && !(t == w + g - 1 && c >= TP - 8);
        else
          safe = !(t == w - 1 && c >= TP - 8);
        nxt = safe && (((t * TP + c) % per) < per / 2);
        if (nxt && !prev && in_gate) emitted++;
        if_in = nxt;
        prev = nxt;
        tick_i = (c == TP - 1);
        if (swap_sel && t == 1 && c == 0) gate_sel_i = ~2'(sel);
      end
    end
    @(negedge clk);
    tick_i = 1'b0; if_in = 1'b0;
    chk("R8 done after last tick", int'(done_o), 1);
    chk("R1 R2 R3 R7 count", int'(count_o), (emitted > TOP) ? TOP : emitted);
    emitted = (emitted > TOP) ? TOP : emitted;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if_in = (k % 4) < 2;
      tick_i = (k % TP) == TP - 1;
    end
    @(negedge clk);
    if_in = 1'b0; tick_i = 1'b0;
    chk("R6 R9 count frozen after window", int'(count_o), emitted);
    chk("R5 R8 done held, no rerun", int'(done_o), 1);
    gate_sel_i = 2'(sel);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    start_i = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 reset count", int'(count_o), 0);
    chk("R4 reset done", int'(done_o), 0);
    for (int k = 0; k < 12 * TP; k++) begin
      @(negedge clk);
      if_in = (k % 4) < 2;
      tick_i = (k % TP) == TP - 1;
    end
    @(negedge clk);
    if_in = 1'b0; tick_i = 1'b0;
    chk("R5 no run from high start at reset", int'(done_o), 0);
    chk("R5 no count from high start at reset", int'(count_o), 0);

    measure(0, 4, 1'b0);
    measure(1, 6, 1'b1);
    measure(2, 10, 1'b0);
    measure(0, 2, 1'b0);
    measure(3, 4, 1'b0);
    measure(2, 14, 1'b1);

    // R4: dropping start in mid-window clears everything
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    gate_sel_i = 2'd1;
    start_i = 1'b1;
    for (int k = 0; k < 5 * TP; k++) begin
      @(negedge clk);
      if_in = (k % 4) < 2;
      tick_i = (k % TP) == TP - 1;
    end
    chk("R1 counting in mid-window", int'(count_o != 0), 1);
    start_i = 1'b0; if_in = 1'b0; tick_i = 1'b0;
    @(negedge clk);
    chk("R4 mid-window clear count", int'(count_o), 0);
    chk("R4 mid-window clear done", int'(done_o), 0);
    measure(1, 4, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule